// File: doc/BRIEF.md
# Bayer Row-Pair Channel Formatter

This block takes raw Bayer pixels from a sensor one row at a time and rearranges them onto two 8-bit output channels, called Y and UV. Even rows of a frame carry blue and green samples (blue at even columns). Odd rows carry green and red samples (green at even columns). A one-row buffer holds the previous row, so each output line can place two neighbouring rows side by side. Because every row meets both its upper and its lower neighbour, it appears on two consecutive output lines.

A two-bit mode chooses how samples are steered. The pair mode places the green/red row on Y and the blue/green row on UV. The green-split mode collects the greens on Y and the blue and red samples on UV. The single mode passes each row straight through on Y. The byte mode interleaves both rows on Y alone at twice the sample rate. The block also drives an enable for the UV channel and a flag that asks for the doubled sample clock. The mode is sampled only at a frame start pulse.

Top module: `bayer_pair_fmt`

## Requirements
- R1: During and after reset, `line_valid_out`, `y_out` and `uv_out` are 0, the active mode is pair (code 0), `uv_oe` is 1 and `pclk_x2` is 0.
- R2: `line_valid_out` equals `line_valid_in` delayed by one clock. Whenever `line_valid_out` is 0, `y_out` and `uv_out` are 0.
- R3: `mode_in` (0 pair, 1 green-split, 2 single, 3 byte) is taken only on a clock where `frame_start` is 1. `uv_oe` is 1 exactly in modes 0 and 1, and `pclk_x2` is 1 exactly in mode 3.
- R4: In pair mode, for the row accepted at column c, the clock after acceptance shows the odd-row sample of column c on `y_out` and the even-row sample on `uv_out`. Here "current" is the incoming row and "previous" is the buffered row, and row parity is counted from 0 at frame start, advancing at each falling edge of `line_valid_in`.
- R5: On the first row after `frame_start`, the previous-row sample reads as 0.
- R6: In green-split mode, at even columns `y_out` is the odd-row sample and `uv_out` is the even-row sample. At odd columns the two are swapped.
- R7: In single mode, `y_out` is the current sample and `uv_out` stays 0.
- R8: In byte mode, `uv_out` stays 0. The clock after an accepted even column shows the even-row sample on `y_out`, and the clock after that shows the odd-row sample. For an odd column the order is reversed.
- R9: A pixel is accepted only when `line_valid_in` and `pix_en` are both 1. In modes 0 to 2, a line clock without acceptance leaves `y_out` and `uv_out` unchanged. In mode 3 such a clock presents the pending second byte once, and the output then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-clock pulse between frames; latches the mode |
| mode_in | input | 2 | Requested steering mode |
| line_valid_in | input | 1 | High across one sensor row |
| pix_en | input | 1 | Qualifies `pix_in` within a row |
| pix_in | input | 8 | Raw Bayer sample |
| line_valid_out | output | 1 | Output line strobe |
| y_out | output | 8 | First output channel |
| uv_out | output | 8 | Second output channel |
| uv_oe | output | 1 | Drive enable for the UV channel |
| pclk_x2 | output | 1 | Doubled sample rate requested |

## Verification
A wrong row-parity bit swaps the two channels for the whole of the next line, so the mismatch appears one clock after the first pixel of that line. A stale first-row flag shows up immediately on the first line of a frame as nonzero data where zero is expected. A buffer addressing fault surfaces only on the second row, as previous-row samples taken from the wrong column. A mode register that moves outside a frame start changes `uv_oe` or `pclk_x2` on the very next clock.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

  localparam int PIX_W = 8;

  typedef enum logic [1:0] {
    MODE_PAIR   = 2'd0,
    MODE_GSPLIT = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_BYTE   = 2'd3
  } bpf_mode_e;

  typedef struct packed {
    logic [PIX_W-1:0] y;
    logic [PIX_W-1:0] uv;
    logic [PIX_W-1:0] late;
  } steer_t;

  function automatic logic uv_enabled(bpf_mode_e m);
    return (m == MODE_PAIR) || (m == MODE_GSPLIT);
  endfunction

  function automatic logic rate_doubled(bpf_mode_e m);
    return m == MODE_BYTE;
  endfunction

  // even rows hold blue/green, odd rows hold green/red
  function automatic steer_t steer(bpf_mode_e m, logic row_odd, logic col_odd,
                                   logic [PIX_W-1:0] cur, logic [PIX_W-1:0] prev);
    logic [PIX_W-1:0] ev_row;
    logic [PIX_W-1:0] od_row;
    steer_t s;
    ev_row = row_odd ? prev : cur;
    od_row = row_odd ? cur  : prev;
    s      = '0;
    case (m)
      MODE_PAIR: begin
        s.y  = od_row;
        s.uv = ev_row;
      end
      MODE_GSPLIT: begin
        s.y  = col_odd ? ev_row : od_row;
        s.uv = col_odd ? od_row : ev_row;
      end
      MODE_SINGLE: begin
        s.y = cur;
      end
      default: begin
        s.y    = col_odd ? od_row : ev_row;
        s.late = col_odd ? ev_row : od_row;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bpf_line_buffer.sv
module bpf_line_buffer #(
  parameter int MAX_W = 64,
  parameter int COL_W = 7,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [COL_W-1:0] addr,
  input  logic [PIX_W-1:0] wr_data,
  output logic [PIX_W-1:0] rd_data
);
  localparam int IDX_W = (MAX_W > 1) ? $clog2(MAX_W) : 1;

  logic [PIX_W-1:0] mem [MAX_W];
  logic [IDX_W-1:0] idx;
  logic             in_range;

  assign idx      = addr[IDX_W-1:0];
  assign in_range = addr < COL_W'(MAX_W);

  // read returns the previous row's sample before this row overwrites it
  assign rd_data = in_range ? mem[idx] : '0;

  always_ff @(posedge clk) begin
    if (wr_en && in_range) mem[idx] <= wr_data;
  end
endmodule

// File: rtl/bpf_line_tracker.sv
module bpf_line_tracker
  import bpf_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [1:0]       mode_req,
  input  logic             line_valid_in,
  input  logic             pix_en,
  output bpf_mode_e        mode_act,
  output logic [COL_W-1:0] col,
  output logic             row_odd,
  output logic             first_row,
  output logic             pix_take,
  output logic             lv_q
);
  logic line_end;

  assign pix_take = line_valid_in & pix_en;
  assign line_end = lv_q & ~line_valid_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_act  <= MODE_PAIR;
      row_odd   <= 1'b0;
      first_row <= 1'b1;
      lv_q      <= 1'b0;
    end else begin
      lv_q <= line_valid_in;
      if (frame_start) begin
        mode_act  <= bpf_mode_e'(mode_req);
        row_odd   <= 1'b0;
        first_row <= 1'b1;
      end else if (line_end) begin
        row_odd   <= ~row_odd;
        first_row <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     col <= '0;
    else if (!line_valid_in)                        col <= '0;
    else if (pix_take && (col != COL_W'(MAX_W)))    col <= col + 1'b1;
  end
endmodule

// File: rtl/bpf_out_stage.sv
module bpf_out_stage
  import bpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_valid_in,
  input  logic             pix_take,
  input  bpf_mode_e        mode_act,
  input  logic             row_odd,
  input  logic             col_odd,
  input  logic [PIX_W-1:0] cur,
  input  logic [PIX_W-1:0] prev,
  output logic [PIX_W-1:0] y_out,
  output logic [PIX_W-1:0] uv_out
);
  steer_t           s;
  logic [PIX_W-1:0] pend_q;
  logic             pend_v;

  assign s = steer(mode_act, row_odd, col_odd, cur, prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out  <= '0;
      uv_out <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (!line_valid_in) begin
      y_out  <= '0;
      uv_out <= '0;
      pend_v <= 1'b0;
    end else if (pix_take) begin
      y_out  <= s.y;
      uv_out <= s.uv;
      pend_q <= s.late;
      pend_v <= rate_doubled(mode_act);
    end else if (pend_v) begin
      y_out  <= pend_q;
      pend_v <= 1'b0;
    end
  end
endmodule

// File: rtl/bayer_pair_fmt.sv
module bayer_pair_fmt
  import bpf_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] mode_in,
  input  logic       line_valid_in,
  input  logic       pix_en,
  input  logic [7:0] pix_in,
  output logic       line_valid_out,
  output logic [7:0] y_out,
  output logic [7:0] uv_out,
  output logic       uv_oe,
  output logic       pclk_x2
);
  localparam int COL_W = $clog2(MAX_W + 1);

  bpf_mode_e        mode_act;
  logic [COL_W-1:0] col;
  logic             row_odd;
  logic             first_row;
  logic             pix_take;
  logic             mode_dflt;
  logic [PIX_W-1:0] buf_rd;
  logic [PIX_W-1:0] prev_px;

  bpf_line_tracker #(.MAX_W(MAX_W), .COL_W(COL_W)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .mode_req      (mode_in),
    .line_valid_in (line_valid_in),
    .pix_en        (pix_en),
    .mode_act      (mode_act),
    .col           (col),
    .row_odd       (row_odd),
    .first_row     (first_row),
    .pix_take      (pix_take),
    .lv_q          (line_valid_out)
  );

  bpf_line_buffer #(.MAX_W(MAX_W), .COL_W(COL_W), .PIX_W(PIX_W)) u_buf (
    .clk     (clk),
    .wr_en   (pix_take),
    .addr    (col),
    .wr_data (pix_in),
    .rd_data (buf_rd)
  );

  assign prev_px   = first_row ? '0 : buf_rd;
  assign mode_dflt = (mode_act == MODE_PAIR);
  assign uv_oe     = uv_enabled(mode_act);
  assign pclk_x2   = rate_doubled(mode_act);

  bpf_out_stage u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_valid_in (line_valid_in),
    .pix_take      (pix_take),
    .mode_act      (mode_act),
    .row_odd       (row_odd),
    .col_odd       (col[0]),
    .cur           (pix_in),
    .prev          (prev_px),
    .y_out         (y_out),
    .uv_out        (uv_out)
  );
endmodule

// File: rtl/bayer_pair_fmt_chk.sv
module bayer_pair_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       line_valid_in,
  input logic       pix_en,
  input logic       line_valid_out,
  input logic [7:0] y_out,
  input logic [7:0] uv_out,
  input logic       uv_oe,
  input logic       pclk_x2,
  input logic       pix_take,
  input logic       first_row,
  input logic       mode_dflt
);
  AST_LV_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid_in |=> line_valid_out); // R2
  AST_LV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid_in |=> !line_valid_out); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid_out |-> (y_out == 8'd0 && uv_out == 8'd0)); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(uv_oe) && $stable(pclk_x2))); // R3
  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_take && first_row && mode_dflt) |=> (y_out == 8'd0)); // R5
  AST_UV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_oe |-> (uv_out == 8'd0)); // R7
  AST_RATE_UV: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_x2 |-> !uv_oe); // R8
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid_in && !pix_en && !pclk_x2 && line_valid_out) |=> ($stable(y_out) && $stable(uv_out))); // R9
endmodule

bind bayer_pair_fmt bayer_pair_fmt_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_start    (frame_start),
  .line_valid_in  (line_valid_in),
  .pix_en         (pix_en),
  .line_valid_out (line_valid_out),
  .y_out          (y_out),
  .uv_out         (uv_out),
  .uv_oe          (uv_oe),
  .pclk_x2        (pclk_x2),
  .pix_take       (pix_take),
  .first_row      (first_row),
  .mode_dflt      (mode_dflt)
);

// File: tb/bayer_pair_fmt_tb.sv
module bayer_pair_fmt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs = 1'b0;
  logic [1:0] md = 2'd0;
  logic       lv = 1'b0;
  logic       pe = 1'b0;
  logic [7:0] px = 8'd0;
  logic       lv_o;
  logic [7:0] y_o, uv_o;
  logic       oe_o, x2_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural reference state
  int    m_mode = 0, m_odd = 0, m_first = 1, m_col = 0, m_lv = 0;
  int    m_y = 0, m_uv = 0, m_pend = 0, m_pv = 0;
  int    mrow[64];
  string tag = "R1";
  int    brow = 0;

  always #2.5 clk = ~clk;

  bayer_pair_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(fs), .mode_in(md),
    .line_valid_in(lv), .pix_en(pe), .pix_in(px),
    .line_valid_out(lv_o), .y_out(y_o), .uv_out(uv_o),
    .uv_oe(oe_o), .pclk_x2(x2_o)
  );

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic model();
    int p, ev, od, co;
    bit take;
    take = lv && pe;
    if (!lv)                             tag = "R2";
    else if (!take && m_mode != 3)       tag = "R9";
    else if (m_first != 0)               tag = "R5";
    else if (m_mode == 0)                tag = "R4";
    else if (m_mode == 1)                tag = "R6";
    else if (m_mode == 2)                tag = "R7";
    else                                 tag = "R8";
    if (!lv) begin
      m_y = 0; m_uv = 0; m_pv = 0;
    end else if (take) begin
      p  = (m_first != 0) ? 0 : mrow[m_col];
      ev = (m_odd != 0) ? p : int'(px);
      od = (m_odd != 0) ? int'(px) : p;
      co = m_col % 2;
      case (m_mode)
        0: begin m_y = od; m_uv = ev; end
        1: begin m_y = (co != 0) ? ev : od; m_uv = (co != 0) ? od : ev; end
        2: begin m_y = int'(px); m_uv = 0; end
        default: begin
          m_y = (co != 0) ? od : ev; m_uv = 0;
          m_pend = (co != 0) ? ev : od; m_pv = 1;
        end
      endcase
      mrow[m_col] = int'(px);
      m_col++;
    end else if (m_pv != 0) begin
      m_y = m_pend; m_pv = 0;
    end
    if (!lv) m_col = 0;
    if (fs) begin
      m_mode = int'(md); m_odd = 0; m_first = 1;
    end else if (m_lv != 0 && !lv) begin
      m_odd = 1 - m_odd; m_first = 0;
    end
    m_lv = lv ? 1 : 0;
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk(tag, "lv_out", int'(lv_o), m_lv);
    chk(tag, "y_out", int'(y_o), m_y);
    chk(tag, "uv_out", int'(uv_o), m_uv);
    chk("R3", "uv_oe", int'(oe_o), (m_mode < 2) ? 1 : 0);
    chk("R3", "pclk_x2", int'(x2_o), (m_mode == 3) ? 1 : 0);
  endtask

  task automatic start_frame(int m);
    md = 2'(m); fs = 1'b1; step(); fs = 1'b0; brow = 0;
    step();
  endtask

  // gap: 0 none, 1 one idle clock after every pixel, 2 idle clock every third pixel
  task automatic send_line(int width, int seed, int gap);
    lv = 1'b1;
    for (int c = 0; c < width; c++) begin
      if (gap == 2 && c % 3 == 1) begin pe = 1'b0; step(); end
      px = 8'(((brow * 37 + c * 11 + seed) % 251) + 1);
      pe = 1'b1; step();
      if (gap == 1) begin pe = 1'b0; step(); end
    end
    pe = 1'b0; lv = 1'b0; px = 8'd0;
    for (int i = 0; i < 3; i++) step();
    brow++;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mrow[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "lv_out", int'(lv_o), 0);
    chk("R1", "y_out", int'(y_o), 0);
    chk("R1", "uv_out", int'(uv_o), 0);
    chk("R1", "uv_oe", int'(oe_o), 1);
    chk("R1", "pclk_x2", int'(x2_o), 0);
    rst_n = 1'b1;
    step();
    // pair mode, then request other modes mid-frame (R3: ignored)
    start_frame(0);
    send_line(8, 3, 0);
    send_line(8, 5, 0);
    md = 2'd2;
    send_line(7, 9, 0);
    md = 2'd3;
    send_line(8, 2, 2);
    // green-split
    start_frame(1);
    for (int l = 0; l < 3; l++) send_line(8, 20 + l, 0);
    // single pass with gaps
    start_frame(2);
    send_line(6, 40, 2);
    send_line(6, 41, 0);
    // byte interleave
    start_frame(3);
    for (int l = 0; l < 3; l++) send_line(8, 60 + l, 1);
    // back to pair, full-width lines with gaps
    start_frame(0);
    send_line(64, 7, 0);
    send_line(64, 8, 2);
    send_line(5, 9, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule